// File: doc/BRIEF.md
# Host Stream Packet Tail Formatter

This block is the sending end of a byte-oriented stream toward a host. A packet is announced by a length in bytes on a request handshake. The data words for that packet then arrive from upstream on a plain valid/ready port. The block emits them as stream beats with TDATA, TKEEP and TLAST. Every beat except the last carries all byte lanes. The last beat carries only the bytes that remain, packed from lane 0 upward, so the host receives exactly the announced byte count.

Nothing leaves the block until the `enable` input (kernel started) is high. While `enable` is low, TVALID stays low and the upstream port refuses data, so no beat can be dropped before the consumer is running. A request with length zero completes the request handshake, produces no beats and leaves the block idle. The bus width in bytes is a parameter, and it must be a power of two from 1 to 64.

Top module: `host_stream_tail_fmt`

## Requirements
- R1: While `m_tvalid` is high, `m_tready` is low and `enable` is high, the next cycle still has `m_tvalid` high, with `m_tdata`, `m_tkeep` and `m_tlast` unchanged.
- R2: A request of length L (in bytes) produces exactly ceil(L / BYTES) beats. Beat k carries the k-th upstream word unmodified.
- R3: On every beat with `m_tlast` low, `m_tkeep` has all BYTES bits set.
- R4: On the final beat, `m_tkeep` equals (1 << r) - 1, where r = L mod BYTES, or all ones when r is 0. `m_tkeep` bit i qualifies byte lane `m_tdata[8*i+7:8*i]`.
- R5: `m_tkeep` is never zero on a cycle where `m_tvalid` is high.
- R6: `m_tlast` is high on the final beat of each packet and low on every other beat.
- R7: While `enable` is low, `m_tvalid` and `in_ready` are both low.
- R8: A request with `req_len` = 0 is accepted (`req_ready` is high) but produces no beat, and `req_ready` is still high on the following cycle.
- R9: `req_ready` is high only when no packet is in progress. After a request with nonzero length is accepted, `req_ready` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Kernel started; gates all output traffic |
| req_valid | input | 1 | Packet request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_len | input | LEN_W | Packet length in bytes |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream word accepted when high with `in_valid` |
| in_data | input | 8*BYTES | Upstream data word |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream consumer ready |
| m_tdata | output | 8*BYTES | Stream data |
| m_tkeep | output | BYTES | Byte-lane qualifiers, bit 0 = lowest lane |
| m_tlast | output | 1 | Final beat of packet |

## Verification
The bench sweeps every packet length from 0 to 17 bytes on a 4-byte bus. This covers each tail remainder several times, the single-beat and exact-multiple cases, and the zero-length request. Each length runs under four consumer back-pressure patterns and three upstream gap patterns. Steady readiness checks keep and last marking at full throughput. Alternating and irregular stalls show whether a held beat changes or a word is lost or duplicated. Some packets hold `enable` low for their first cycles with data already offered, which shows whether gating leaks a beat or pulls data in early.

// File: rtl/stf_pkg.sv
package stf_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } stf_state_e;
endpackage

// File: rtl/stf_pkt_ctrl.sv
module stf_pkt_ctrl #(
  parameter int BYTES  = 4,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = LEN_W + 1,
  parameter int TAIL_W = $clog2(BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              beat_take,
  output logic              req_ready,
  output logic              busy,
  output logic              final_beat,
  output logic [TAIL_W-1:0] tail_cnt
);
  import stf_pkg::*;

  stf_state_e        state_q, state_d;
  logic [CNT_W-1:0]  beats_q, beats_d;
  logic [TAIL_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0]  len_ext, rem, beats_calc;
  logic              accept;

  assign len_ext    = {1'b0, req_len};
  assign rem        = len_ext % CNT_W'(BYTES);
  assign beats_calc = (len_ext + CNT_W'(BYTES - 1)) / CNT_W'(BYTES);

  assign req_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q == ST_BUSY);
  assign accept     = req_valid && req_ready && (req_len != '0);
  assign final_beat = (beats_q == CNT_W'(1));
  assign tail_cnt   = tail_q;

  always_comb begin
    state_d = state_q;
    beats_d = beats_q;
    tail_d  = tail_q;
    if (accept) begin
      state_d = ST_BUSY;
      beats_d = beats_calc;
      tail_d  = (rem == '0) ? TAIL_W'(BYTES) : TAIL_W'(rem);
    end else if (beat_take) begin
      beats_d = beats_q - CNT_W'(1);
      if (final_beat) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beats_q <= '0;
      tail_q  <= '0;
    end else begin
      state_q <= state_d;
      beats_q <= beats_d;
      tail_q  <= tail_d;
    end
  end
endmodule

// File: rtl/stf_keep_gen.sv
module stf_keep_gen #(
  parameter int BYTES  = 4,
  parameter int TAIL_W = $clog2(BYTES + 1)
) (
  input  logic              final_beat,
  input  logic [TAIL_W-1:0] tail_cnt,
  output logic [BYTES-1:0]  keep
);
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign keep[i] = !final_beat || (TAIL_W'(i) < tail_cnt);
  end
endmodule

// File: rtl/stf_out_slice.sv
module stf_out_slice #(
  parameter int BYTES  = 4,
  parameter int DATA_W = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              pop,
  input  logic [DATA_W-1:0] data_in,
  input  logic [BYTES-1:0]  keep_in,
  input  logic              last_in,
  output logic              valid_q,
  output logic [DATA_W-1:0] data_q,
  output logic [BYTES-1:0]  keep_q,
  output logic              last_q
);
  logic valid_d;

  always_comb begin
    valid_d = valid_q;
    if (load)     valid_d = 1'b1;
    else if (pop) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      keep_q <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      data_q <= data_in;
      keep_q <= keep_in;
      last_q <= last_in;
    end
  end
endmodule

// File: rtl/host_stream_tail_fmt.sv
module host_stream_tail_fmt #(
  parameter int BYTES = 4,
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [8*BYTES-1:0] in_data,
  output logic               m_tvalid,
  input  logic               m_tready,
  output logic [8*BYTES-1:0] m_tdata,
  output logic [BYTES-1:0]   m_tkeep,
  output logic               m_tlast
);
  localparam int DATA_W = 8 * BYTES;
  localparam int CNT_W  = LEN_W + 1;
  localparam int TAIL_W = $clog2(BYTES + 1);

  logic              busy, final_beat, take, pop, space, vld_q;
  logic [TAIL_W-1:0] tail_cnt;
  logic [BYTES-1:0]  keep_nx;

  assign m_tvalid = vld_q && enable;
  assign pop      = m_tvalid && m_tready;
  assign space    = !vld_q || pop;
  assign in_ready = enable && busy && space;
  assign take     = in_valid && in_ready;

  stf_pkt_ctrl #(.BYTES(BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W), .TAIL_W(TAIL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .beat_take  (take),
    .req_ready  (req_ready),
    .busy       (busy),
    .final_beat (final_beat),
    .tail_cnt   (tail_cnt)
  );

  stf_keep_gen #(.BYTES(BYTES), .TAIL_W(TAIL_W)) u_keep (
    .final_beat (final_beat),
    .tail_cnt   (tail_cnt),
    .keep       (keep_nx)
  );

  stf_out_slice #(.BYTES(BYTES), .DATA_W(DATA_W)) u_slice (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .pop     (pop),
    .data_in (in_data),
    .keep_in (keep_nx),
    .last_in (final_beat),
    .valid_q (vld_q),
    .data_q  (m_tdata),
    .keep_q  (m_tkeep),
    .last_q  (m_tlast)
  );
endmodule

// File: rtl/stf_checker.sv
module stf_checker #(
  parameter int BYTES = 4,
  parameter int LEN_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               req_valid,
  input logic               req_ready,
  input logic [LEN_W-1:0]   req_len,
  input logic               in_ready,
  input logic               m_tvalid,
  input logic               m_tready,
  input logic [8*BYTES-1:0] m_tdata,
  input logic [BYTES-1:0]   m_tkeep,
  input logic               m_tlast
);
  a_r1_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready && enable) |=>
      (!enable || (m_tvalid && $stable({m_tdata, m_tkeep, m_tlast}))));

  a_r3_full_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tlast) |-> (&m_tkeep));

  a_r4_low_run: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tlast) |-> (((m_tkeep + BYTES'(1)) & m_tkeep) == '0));

  a_r5_keep_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tkeep != '0));

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!m_tvalid && !in_ready));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len != '0)) |=> !req_ready);

  a_r8_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len == '0)) |=> req_ready);
endmodule

bind host_stream_tail_fmt stf_checker #(.BYTES(BYTES), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/test_host_stream_tail_fmt.sv
`timescale 1ns/1ps
module test_host_stream_tail_fmt;
  localparam int BYTES = 4;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n, enable, req_valid, in_valid, m_tready;
  logic             req_ready, in_ready, m_tvalid, m_tlast;
  logic [LEN_W-1:0] req_len;
  logic [31:0]      in_data, m_tdata;
  logic [3:0]       m_tkeep;

  int tests = 0;
  int fails = 0;
  int pkt_id = 0;

  always #2 clk = ~clk;

  host_stream_tail_fmt #(.BYTES(BYTES), .LEN_W(LEN_W)) i_host_stream_tail_fmt (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tlast(m_tlast)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (packet %0d)", req, act, exp, pkt_id);
    end
  endtask

  function automatic bit pat(input int p, input int c);
    case (p)
      0: return 1'b1;
      1: return (c % 2) == 0;
      2: return (c % 3) != 0;
      default: return ((c * 7) % 5) < 2;
    endcase
  endfunction

  task automatic do_pkt(input int len, input int rpat, input int vpat, input bit gate_first);
    int nb = (len + BYTES - 1) / BYTES;
    int rem = len % BYTES;
    logic [3:0] last_keep = (rem == 0) ? 4'hF : 4'((1 << rem) - 1);
    int sent = 0, rcv = 0, cyc = 0, tail = 0;
    bit req_done = 0, accept_seen = 0, stall = 0, gate_ok = 1;
    logic [36:0] prev = '0;
    pkt_id++;
    while (tail < 3 && cyc < 600) begin
      @(negedge clk);
      cyc++;
      req_valid = !req_done;
      req_len   = LEN_W'(len);
      enable    = gate_first ? (cyc > 8) : 1'b1;
      m_tready  = pat(rpat, cyc);
      in_valid  = req_done && (sent < nb) && pat(vpat, cyc + 1);
      in_data   = {8'(pkt_id), 8'(len), 16'(sent)};
      #1;
      if (accept_seen) begin
        accept_seen = 0;
        if (nb == 0) chk(req_ready, "R8 idle after zero-length request", 32'(req_ready), 32'd1);
        else if (enable) chk(!req_ready, "R9 busy after accept", 32'(req_ready), 32'd0);
      end
      if (!enable && (m_tvalid || in_ready)) gate_ok = 0;
      if (stall) begin
        if (enable)
          chk(m_tvalid && ({m_tdata, m_tkeep, m_tlast} == prev), "R1 stalled beat held",
              32'({m_tvalid, m_tkeep, m_tlast}), 32'({1'b1, prev[4:0]}));
      end
      if (m_tvalid && m_tready) begin
        if (rcv >= nb) begin
          chk(1'b0, "R2/R8 extra beat", 32'(rcv), 32'(nb));
        end else begin
          bit fin = (rcv == nb - 1);
          chk(m_tdata == {8'(pkt_id), 8'(len), 16'(rcv)}, "R2 beat data order", m_tdata,
              {8'(pkt_id), 8'(len), 16'(rcv)});
          chk(m_tlast == fin, "R6 last marking", 32'(m_tlast), 32'(fin));
          chk(m_tkeep != 4'h0, "R5 keep nonzero", 32'(m_tkeep), 32'hF);
          if (fin) chk(m_tkeep == last_keep, "R4 tail keep", 32'(m_tkeep), 32'(last_keep));
          else     chk(m_tkeep == 4'hF, "R3 full keep", 32'(m_tkeep), 32'hF);
        end
        rcv++;
      end
      stall = m_tvalid && !m_tready;
      prev  = {m_tdata, m_tkeep, m_tlast};
      if (in_valid && in_ready) sent++;
      if (req_valid && req_ready) begin
        req_done = 1;
        accept_seen = 1;
      end
      if (req_done && rcv >= nb && !accept_seen) tail++;
    end
    req_valid = 0;
    in_valid  = 0;
    chk(rcv == nb, "R2 beat count", 32'(rcv), 32'(nb));
    if (gate_first) chk(gate_ok, "R7 gated while disabled", 32'(gate_ok), 32'd1);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 0; req_valid = 0; req_len = '0;
    in_valid = 0; in_data = '0; m_tready = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!m_tvalid, "R7 reset tvalid low", 32'(m_tvalid), 32'd0);
    chk(req_ready, "R9 reset idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    rst_n = 1;
    for (int len = 0; len < 18; len++)
      for (int rp = 0; rp < 4; rp++)
        for (int vp = 0; vp < 3; vp++)
          do_pkt(len, rp, vp, (len % 3) == 1 && vp == 2);
    do_pkt(0, 0, 0, 0);
    do_pkt(13, 3, 1, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule